// File: doc/BRIEF.md
# Split-Aware Round-Robin Bus Arbiter

This block arbitrates among several masters that share one pipelined bus. The address phase of one transfer and the data phase of the one before it share a cycle, so the master that owns the data phase can differ from the master that holds the grant. The arbiter tracks both owners. The grant moves only on a cycle where the slave's ready signal is high. While ready is low, the address-phase owner and the data-phase owner both hold their values.

A slave may refuse to finish a transfer by giving a two-cycle split response. In the first cycle ready is low. The arbiter records the data-phase owner of that transfer. In the second cycle ready is high, and the arbiter sets that master's bit in a per-master mask. Arbitration on that same edge already leaves the master out, so the grant moves to another requester. A masked master's request has no effect until the slave pulses that master's bit on `split_resume`. Grants rotate round-robin, starting from the master after the current owner. When no unmasked master is requesting, master 0 is granted as the default.

Top module: `split_arbiter`

## Requirements
- R1: After reset, `grant` is 4'b0001, `master_id` is 0 and no master is masked.
- R2: `grant` is always one-hot, and its set bit is at position `master_id`.
- R3: In any cycle where `ready` is low, `grant` and `master_id` do not change at the next edge.
- R4: On a ready-high edge, the new owner is the first eligible requester found by scanning upward from the current owner plus one, wrapping around. The current owner is scanned last. An eligible requester is one whose request is high and which is not masked.
- R5: On a ready-high edge with no eligible requester, master 0 is granted.
- R6: The master recorded for a split is the data-phase owner. This is the master that held the grant on the most recent ready-high edge before the first split cycle. It is not the current grantee.
- R7: A split is a cycle with `resp` = 2'b11 (SPLIT) and `ready` low, followed by a cycle with `resp` = 2'b11 and `ready` high. On that second edge, the recorded master's mask bit is set and the master is left out of that arbitration.
- R8: A masked master's request is ignored. If it is the only requester, master 0 is granted.
- R9: A pulse on `split_resume[i]` clears mask bit i at that edge, and master i can be granted from the next ready-high edge on.
- R10: If a split sets bit i on the same edge that `split_resume[i]` is high, the bit ends up set.
- R11: The responses OKAY (2'b00), ERROR (2'b01) and RETRY (2'b10) never mask a master.
- R12: A master that keeps requesting while unmasked is granted within N ready-high edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Request line per master |
| resp | input | 2 | Slave response code: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| ready | input | 1 | Slave ready; low stretches the data phase |
| split_resume | input | N | Per-master pulse that unmasks a split master |
| grant | output | N | One-hot address-phase grant |
| master_id | output | log2(N) | Index of the address-phase owner |

## Verification
Two functions can act on the same mask bit in one cycle: the second cycle of a split sets a master's bit while `split_resume` clears it. The bench provokes this on purpose, with a resume pulse arriving in the very cycle that completes a split for the same master. It then judges at the grant output that the master stays locked out on later edges. The bench also completes a split while the grantee differs from the data-phase owner, so that the masked master can be told apart from the current one. Every cycle is compared against a behavioural reference model, under random request, ready, response and resume traffic.

// File: rtl/split_arb_pkg.sv
package split_arb_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } bus_resp_e;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N      = 4,
  parameter int DEF_ID = 0,
  localparam int IDW   = $clog2(N)
) (
  input  logic [IDW-1:0] cur_id,
  input  logic [N-1:0]   eligible,
  output logic [IDW-1:0] next_id
);
  always_comb begin
    logic found;
    found   = 1'b0;
    next_id = IDW'(DEF_ID);
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(cur_id) + k) % N;
      if (!found && eligible[idx]) begin
        found   = 1'b1;
        next_id = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/owner_pipe.sv
module owner_pipe #(
  parameter int N      = 4,
  parameter int DEF_ID = 0,
  localparam int IDW   = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic [IDW-1:0] next_id,
  output logic [IDW-1:0] addr_id,
  output logic [IDW-1:0] data_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_id <= IDW'(DEF_ID);
      data_id <= IDW'(DEF_ID);
    end else if (advance) begin
      addr_id <= next_id;
      data_id <= addr_id;
    end
  end
endmodule

// File: rtl/split_tracker.sv
module split_tracker
  import split_arb_pkg::*;
#(
  parameter int N    = 4,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     resp,
  input  logic           ready,
  input  logic [IDW-1:0] data_id,
  input  logic [N-1:0]   resume,
  output logic [N-1:0]   mask_q,
  output logic [N-1:0]   mask_eff
);
  logic           pend_q;
  logic [IDW-1:0] pid_q;
  logic [N-1:0]   pid_oh;
  logic [N-1:0]   set_vec;
  logic           first_cyc;

  assign first_cyc = (resp == RSP_SPLIT) && !ready && !pend_q;
  assign pid_oh    = N'(1) << pid_q;
  assign set_vec   = (pend_q && ready && resp == RSP_SPLIT) ? pid_oh : '0;
  assign mask_eff  = mask_q | (pend_q ? pid_oh : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pid_q  <= '0;
    end else if (first_cyc) begin
      pend_q <= 1'b1;
      pid_q  <= data_id;
    end else if (ready) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q & ~resume) | set_vec;
  end
endmodule

// File: rtl/split_arbiter.sv
module split_arbiter #(
  parameter int N      = 4,
  parameter int DEF_ID = 0,
  localparam int IDW   = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [1:0]     resp,
  input  logic           ready,
  input  logic [N-1:0]   split_resume,
  output logic [N-1:0]   grant,
  output logic [IDW-1:0] master_id
);
  logic [IDW-1:0] addr_id;
  logic [IDW-1:0] data_id;
  logic [IDW-1:0] next_id;
  logic [N-1:0]   mask_q;
  logic [N-1:0]   mask_eff;
  logic [N-1:0]   eligible;

  assign eligible = req & ~mask_eff;

  rr_picker #(.N(N), .DEF_ID(DEF_ID)) u_pick (
    .cur_id(addr_id), .eligible(eligible), .next_id(next_id)
  );

  owner_pipe #(.N(N), .DEF_ID(DEF_ID)) u_pipe (
    .clk(clk), .rst_n(rst_n), .advance(ready), .next_id(next_id),
    .addr_id(addr_id), .data_id(data_id)
  );

  split_tracker #(.N(N)) u_split (
    .clk(clk), .rst_n(rst_n), .resp(resp), .ready(ready), .data_id(data_id),
    .resume(split_resume), .mask_q(mask_q), .mask_eff(mask_eff)
  );

  assign grant     = N'(1) << addr_id;
  assign master_id = addr_id;
endmodule

// File: rtl/split_arbiter_chk.sv
module split_arbiter_chk
  import split_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int DEF_ID = 0,
  localparam int IDW   = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic [1:0]     resp,
  input logic           ready,
  input logic [N-1:0]   split_resume,
  input logic [N-1:0]   grant,
  input logic [IDW-1:0] master_id,
  input logic [N-1:0]   split_mask
);
  localparam logic [N-1:0] DEF_OH = N'(1) << DEF_ID;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(grant) && grant[master_id]); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(grant) && $stable(master_id)); // R3

  AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & split_mask & ~DEF_OH) == '0); // R8

  for (genvar i = 0; i < N; i++) begin : g_m
    int unsigned wait_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       wait_cnt <= 0;
      else if (!req[i] || split_mask[i] || grant[i])    wait_cnt <= 0;
      else if (ready)                                   wait_cnt <= wait_cnt + 1;
    end

    AST_MASK_RISE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(split_mask[i]) |-> $past(ready && resp == RSP_SPLIT)); // R7

    AST_MASK_FALL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(split_mask[i]) |-> $past(split_resume[i])); // R9

    AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= N); // R12
  end
endmodule

bind split_arbiter split_arbiter_chk #(.N(N), .DEF_ID(DEF_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .resp(resp), .ready(ready),
  .split_resume(split_resume), .grant(grant), .master_id(master_id),
  .split_mask(mask_q)
);

// File: tb/split_arbiter_bench.sv
`timescale 1ns/1ps
module split_arbiter_bench;
  localparam int N = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [1:0] resp = 2'b00;
  logic ready = 1'b1;
  logic [N-1:0] resume = '0;
  logic [N-1:0] grant;
  logic [IDW-1:0] master_id;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  split_arbiter #(.N(N), .DEF_ID(0)) u_split_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .resp(resp), .ready(ready),
    .split_resume(resume), .grant(grant), .master_id(master_id)
  );

  // behavioural reference
  int m_owner, m_data, m_pend, m_pid;
  bit m_mask[N];
  int waitc[N];

  function automatic int pick(int cur, logic [N-1:0] r, bit mk[N], int pend, int pid);
    for (int k = 1; k <= N; k++) begin
      int j = (cur + k) % N;
      if (r[j] && !mk[j] && !(pend != 0 && pid == j)) return j;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = 0; m_data = 0; m_pend = 0; m_pid = 0;
      for (int i = 0; i < N; i++) m_mask[i] = 0;
    end else begin
      int nxt, setb;
      setb = -1;
      if (ready) begin
        nxt = pick(m_owner, req, m_mask, m_pend, m_pid);
        if (m_pend != 0 && resp == 2'b11) setb = m_pid;
        m_pend = 0;
        m_data = m_owner;
        m_owner = nxt;
      end else if (resp == 2'b11 && m_pend == 0) begin
        m_pend = 1;
        m_pid = m_data;
      end
      for (int i = 0; i < N; i++) begin
        if (resume[i]) m_mask[i] = 0;
        if (i == setb) m_mask[i] = 1;
      end
    end
  end

  task automatic expect_eq(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic compare();
    expect_eq({tag, " master_id"}, int'(master_id), m_owner);
    expect_eq("R2 grant", int'(grant), 1 << m_owner);
    for (int i = 0; i < N; i++) begin
      if (grant[i] || !req[i] || m_mask[i]) waitc[i] = 0;
      if (waitc[i] > N) expect_eq("R12 wait", waitc[i], N);
    end
  endtask

  always @(posedge clk) if (rst_n)
    for (int i = 0; i < N; i++) if (ready && req[i] && !m_mask[i] && !grant[i]) waitc[i]++;

  task automatic cyc(logic [N-1:0] r, logic [1:0] rs, logic rd, logic [N-1:0] res);
    @(negedge clk);
    compare();
    req = r; resp = rs; ready = rd; resume = res;
  endtask

  task automatic chk_id(string t, int exp);
    @(posedge clk); #2;
    expect_eq(t, int'(master_id), exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) waitc[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_eq("R1 grant", int'(grant), 1);
    expect_eq("R1 master_id", int'(master_id), 0);
    tag = "R5";
    cyc(4'b0000, 2'b00, 1, 0); chk_id("R5 idle default", 0);
    // R7, R8, R9: split on master 2
    tag = "R7";
    cyc(4'b0100, 2'b00, 1, 0); chk_id("R7 setup", 2);
    cyc(4'b0100, 2'b00, 1, 0);
    cyc(4'b0100, 2'b11, 0, 0);
    cyc(4'b0110, 2'b11, 1, 0); chk_id("R7 grant moves off split master", 1);
    tag = "R8";
    cyc(4'b0100, 2'b00, 1, 0); chk_id("R8 masked request ignored", 0);
    tag = "R9";
    cyc(4'b0100, 2'b00, 1, 4'b0100); chk_id("R9 resume edge", 0);
    cyc(4'b0100, 2'b00, 1, 0); chk_id("R9 regrant after resume", 2);
    // R6: split recorded for data-phase owner
    tag = "R6";
    cyc(4'b0010, 2'b00, 1, 0); chk_id("R6 setup a", 1);
    cyc(4'b1000, 2'b00, 1, 0); chk_id("R6 setup b", 3);
    cyc(4'b1000, 2'b11, 0, 0);
    cyc(4'b1010, 2'b11, 1, 0); chk_id("R6 grantee kept", 3);
    cyc(4'b0010, 2'b00, 1, 0); chk_id("R6 data owner masked", 0);
    cyc(4'b0000, 2'b00, 1, 4'b0010);
    // R10: split and resume of same master in one cycle
    tag = "R10";
    cyc(4'b1000, 2'b00, 1, 0); chk_id("R10 setup", 3);
    cyc(4'b1000, 2'b00, 1, 0);
    cyc(4'b1000, 2'b11, 0, 0);
    cyc(4'b1001, 2'b11, 1, 4'b1000); chk_id("R10 split edge", 0);
    cyc(4'b1000, 2'b00, 1, 0); chk_id("R10 still masked", 0);
    cyc(4'b0000, 2'b00, 1, 4'b1000);
    // R11: retry/error do not mask
    tag = "R11";
    cyc(4'b0100, 2'b00, 1, 0); chk_id("R11 setup", 2);
    cyc(4'b0100, 2'b10, 0, 0);
    cyc(4'b0100, 2'b10, 1, 0); chk_id("R11 retry no mask", 2);
    cyc(4'b0100, 2'b01, 1, 0); chk_id("R11 error no mask", 2);
    // R3: stall holds grant
    tag = "R3";
    cyc(4'b1011, 2'b00, 0, 0); chk_id("R3 hold a", 2);
    cyc(4'b1011, 2'b00, 0, 0); chk_id("R3 hold b", 2);
    // R4: rotation
    tag = "R4";
    cyc(4'b1111, 2'b00, 1, 0); chk_id("R4 rot 3", 3);
    cyc(4'b1111, 2'b00, 1, 0); chk_id("R4 rot 0", 0);
    cyc(4'b1111, 2'b00, 1, 0); chk_id("R4 rot 1", 1);
    cyc(4'b0101, 2'b00, 1, 0); chk_id("R4 skip to 2", 2);
    // random traffic, R12 fairness tracked in compare
    tag = "R12";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] rs;
      int u;
      u = $urandom % 8;
      rs = (u < 2) ? 2'b11 : (u == 2) ? 2'b10 : (u == 3) ? 2'b01 : 2'b00;
      cyc(N'($urandom), rs, ($urandom % 4) != 0,
          (($urandom % 6) == 0) ? N'($urandom) : '0);
    end
    cyc(4'b0000, 2'b00, 1, 4'b1111);
    cyc(4'b0000, 2'b00, 1, 0);
    @(negedge clk); compare();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule